// File: doc/BRIEF.md
# Multi-Polynomial Bit-Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock with a linear feedback shift register. The generator is chosen at run time from five polynomials of degree 3, 8, 16, 32 and 40. All five share one 40-bit register, and only the low bits that belong to the chosen degree take part. The block divides the augmented message: the register is cleared, the message enters most significant bit first, and the block then feeds in as many zero bits as the degree on its own. The register is left holding the remainder.

A transfer begins with a start pulse that also samples the polynomial select. The message bits follow, each marked valid, and the final one carries a last flag. After the padding the block raises a one-cycle done pulse. The remainder and a zero-remainder flag stay readable until the next start. A sender appends the remainder to the message. A receiver runs the whole codeword through the block: a zero remainder means no error was found, and a nonzero remainder means the codeword is corrupt.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, crc_o is 0, done_o is 0 and zero_o is 1.
- R2: sel_i is sampled on the cycle start_i is accepted and chooses the generator. Code 0 is degree 16 with low bits 0x1021. Code 1 is degree 32 with low bits 0x04C11DB7. Code 2 is degree 3 with low bits 0x3. Code 3 is degree 8 with low bits 0x1D. Code 4 is degree 40 with low bits 0x0004820009. Codes 5, 6 and 7 behave exactly as code 0.
- R3: Once started, each cycle with bit_valid_i high shifts in bit_i, with the first bit as the highest-degree coefficient. Cycles with bit_valid_i low leave the register untouched.
- R4: A valid bit with last_i high ends the message. The block then appends exactly degree zero bits, one per cycle, and done_o is high for exactly one cycle: the cycle after the degree-th clock edge that follows the edge that sampled the last bit.
- R5: When done_o is high, crc_o equals the remainder of m(x)·x^degree divided by g(x), right-aligned, with every bit at or above the degree equal to zero. For a one-bit message of value 1, this remainder is the polynomial's low bits.
- R6: zero_o is high exactly when crc_o is zero. A codeword made of a message followed by its remainder (MSB first) yields zero_o high. The same codeword with one bit inverted yields zero_o low.
- R7: While a computation runs, changes on sel_i and pulses on start_i have no effect on the result.
- R8: After done_o, crc_o and zero_o hold their values until the next accepted start.
- R9: bit_valid_i, bit_i and last_i are ignored while the block is idle, on the cycle start_i is accepted, and during the appended zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 3 | Generator polynomial select, sampled at start |
| start_i | input | 1 | Clears the register and begins a computation when idle |
| bit_valid_i | input | 1 | bit_i carries a message bit this cycle |
| bit_i | input | 1 | Message bit, most significant first |
| last_i | input | 1 | Marks the final valid message bit |
| crc_o | output | 40 | Remainder, right-aligned to the selected degree |
| done_o | output | 1 | One-cycle pulse when the remainder is ready |
| zero_o | output | 1 | High when the remainder is zero |

## Verification
The assertions check on every cycle the following: done_o follows the final padding step and lasts one cycle, the pad counter never reaches the padding state at zero, the latched select stays stable while busy, the register holds while idle, and no remainder bit lies above the degree. Whether the remainder is the correct polynomial remainder can only be shown by the bench. It compares every result against an independent long-division model for all five generators and the alias codes, on random lengths, with gaps between bits and with disturbances in the middle of a run. The bench also measures the padding latency per degree and checks that codewords give a zero remainder while corrupted ones do not.

// File: rtl/crc_eng_pkg.sv
`timescale 1ns/1ps
package crc_eng_pkg;
  localparam int unsigned CRC_MAX_W = 40;
  localparam int unsigned DEG_W     = $clog2(CRC_MAX_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAD} eng_state_e;

  // low coefficient bits; the x^deg term is implicit
  function automatic logic [CRC_MAX_W-1:0] poly_low(input logic [2:0] sel);
    case (sel)
      3'd1:    return 40'h00_04C1_1DB7;
      3'd2:    return 40'h00_0000_0003;
      3'd3:    return 40'h00_0000_001D;
      3'd4:    return 40'h00_0482_0009;
      default: return 40'h00_0000_1021;
    endcase
  endfunction

  function automatic logic [DEG_W-1:0] poly_deg(input logic [2:0] sel);
    case (sel)
      3'd1:    return DEG_W'(32);
      3'd2:    return DEG_W'(3);
      3'd3:    return DEG_W'(8);
      3'd4:    return DEG_W'(40);
      default: return DEG_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/crc_lfsr_step.sv
`timescale 1ns/1ps
module crc_lfsr_step #(
  parameter int unsigned W  = 40,
  parameter int unsigned DW = $clog2(W + 1)
) (
  input  logic [W-1:0]  cur_i,
  input  logic [W-1:0]  poly_i,
  input  logic [DW-1:0] deg_i,
  input  logic          bit_i,
  output logic [W-1:0]  nxt_o
);
  logic [DW-1:0] top_idx;
  logic          fb;

  assign top_idx = deg_i - 1'b1;
  assign fb      = cur_i[top_idx];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic keep;
    assign keep = (DW'(i) < deg_i);
    if (i == 0) begin : g_lsb
      assign nxt_o[i] = keep & (bit_i ^ (fb & poly_i[i]));
    end else begin : g_up
      assign nxt_o[i] = keep & (cur_i[i-1] ^ (fb & poly_i[i]));
    end
  end
endmodule

// File: rtl/crc_seq_ctrl.sv
`timescale 1ns/1ps
module crc_seq_ctrl
  import crc_eng_pkg::*;
#(
  parameter int unsigned DW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bit_valid_i,
  input  logic          last_i,
  input  logic [DW-1:0] deg_i,
  output logic          load_o,
  output logic          step_o,
  output logic          pad_o,
  output logic          busy_o,
  output logic          done_o
);
  eng_state_e    state_q, state_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          done_q;
  logic          pad_end;

  assign pad_end = (state_q == ST_PAD) && (cnt_q == DW'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    pad_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = ST_MSG;
      end
      ST_MSG: if (bit_valid_i) begin
        step_o = 1'b1;
        if (last_i) begin
          state_d = ST_PAD;
          cnt_d   = deg_i;
        end
      end
      ST_PAD: begin
        step_o = 1'b1;
        pad_o  = 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (pad_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= pad_end;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  assert_done_after_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_end |=> done_o);
  assert_done_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pad_count_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD) |-> (cnt_q != '0));
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE));
endmodule

// File: rtl/crc_serial_engine.sv
`timescale 1ns/1ps
module crc_serial_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned REG_W = CRC_MAX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       sel_i,
  input  logic             start_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic [REG_W-1:0] crc_o,
  output logic             done_o,
  output logic             zero_o
);
  localparam int unsigned DW = $clog2(REG_W + 1);

  logic [2:0]       sel_q;
  logic [REG_W-1:0] crc_q, crc_nxt, poly;
  logic [DW-1:0]    deg;
  logic             load, step, pad, busy, shift_bit;

  assign poly      = REG_W'(poly_low(sel_q));
  assign deg       = DW'(poly_deg(sel_q));
  assign shift_bit = pad ? 1'b0 : bit_i;

  crc_seq_ctrl #(.DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bit_valid_i (bit_valid_i),
    .last_i      (last_i),
    .deg_i       (deg),
    .load_o      (load),
    .step_o      (step),
    .pad_o       (pad),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  crc_lfsr_step #(.W(REG_W), .DW(DW)) u_step (
    .cur_i  (crc_q),
    .poly_i (poly),
    .deg_i  (deg),
    .bit_i  (shift_bit),
    .nxt_o  (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      crc_q <= '0;
    end else if (load) begin
      sel_q <= sel_i;
      crc_q <= '0;
    end else if (step) begin
      crc_q <= crc_nxt;
    end
  end

  assign crc_o  = crc_q;
  assign zero_o = ~|crc_q;

  assert_sel_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(sel_q));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(crc_q));
  assert_upper_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((crc_q >> deg) == '0));
endmodule

// File: tb/sim_crc_serial_engine.sv
`timescale 1ns/1ps
module sim_crc_serial_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  sel_i = '0;
  logic        start_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, last_i = 1'b0;
  logic [39:0] crc_o;
  logic        done_o, zero_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit ended   = 1'b0;

  always #2 clk = ~clk;

  crc_serial_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .start_i(start_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .last_i(last_i),
    .crc_o(crc_o), .done_o(done_o), .zero_o(zero_o)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected <=150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_deg(input logic [2:0] s);
    case (s)
      3'd1: return 32; 3'd2: return 3; 3'd3: return 8; 3'd4: return 40;
      default: return 16;
    endcase
  endfunction

  function automatic logic [39:0] ref_low(input logic [2:0] s);
    case (s)
      3'd1: return 40'h04C11DB7; 3'd2: return 40'h3; 3'd3: return 40'h1D;
      3'd4: return 40'h0004820009;
      default: return 40'h1021;
    endcase
  endfunction

  // long division over an explicit dividend array
  function automatic logic [39:0] ref_rem(input logic [2:0] s, input int len, input logic [0:299] m);
    logic [0:339] a;
    logic [0:40]  g;
    logic [39:0]  r;
    int d;
    d = ref_deg(s);
    a = '0;
    for (int i = 0; i < len; i++) a[i] = m[i];
    g = '0;
    for (int j = 0; j <= d; j++) g[j] = (j == 0) ? 1'b1 : ref_low(s)[d-j];
    for (int i = 0; i < len; i++)
      if (a[i]) for (int j = 0; j <= d; j++) a[i+j] = a[i+j] ^ g[j];
    r = '0;
    for (int k = 0; k < d; k++) r = {r[38:0], a[len+k]};
    return r;
  endfunction

  function automatic logic [0:299] rnd_msg();
    logic [0:299] m;
    for (int i = 0; i < 300; i++) m[i] = 1'($urandom_range(0, 1));
    return m;
  endfunction

  task automatic do_run(input logic [2:0] sel, input int len, input logic [0:299] m,
                        input bit gaps, input bit disturb,
                        output logic [39:0] rc, output logic rz, output int lat, output bit pulse_ok);
    @(negedge clk);
    sel_i = sel; start_i = 1'b1;
    bit_valid_i = 1'b1; bit_i = 1'b1; last_i = 1'b1;  // R9: ignored on the start cycle
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      bit_valid_i = 1'b1; bit_i = m[i]; last_i = (i == len - 1);
      if (disturb && i == len / 2) begin sel_i = sel ^ 3'd1; start_i = 1'b1; end
      @(negedge clk);
      start_i = 1'b0;
      if (gaps && i != len - 1) begin
        bit_valid_i = 1'b0; bit_i = ~m[i]; last_i = 1'b1;
        repeat (1 + (i % 3)) @(negedge clk);
      end
    end
    bit_valid_i = 1'b1; bit_i = 1'b1; last_i = 1'b0;  // R9: ignored during padding
    lat = 0;
    while (!done_o && lat < 60) begin @(negedge clk); lat++; end
    bit_valid_i = 1'b0; bit_i = 1'b0;
    rc = crc_o; rz = zero_o;
    @(negedge clk);
    pulse_ok = !done_o;
  endtask

  task automatic t_reset();
    chk(crc_o == 40'h0, "R1 crc at reset", crc_o, 0);
    chk(done_o == 1'b0, "R1 done at reset", done_o, 0);
    chk(zero_o == 1'b1, "R1 zero at reset", zero_o, 1);
  endtask

  task automatic t_single_one();
    logic [39:0] rc; logic rz; int lat; bit p;
    for (int s = 0; s < 5; s++) begin
      do_run(3'(s), 1, 300'h0 | (300'b1 << 299), 1'b0, 1'b0, rc, rz, lat, p);
      chk(rc == ref_low(3'(s)), "R5 one-bit message gives low bits", rc, ref_low(3'(s)));
      chk(lat == ref_deg(3'(s)), "R4 padding latency", lat, ref_deg(3'(s)));
      chk(p, "R4 done lasts one cycle", !p, 0);
    end
  endtask

  task automatic t_random_all();
    logic [39:0] rc, ex; logic rz; int lat; bit p; int len; logic [0:299] m;
    for (int s = 0; s < 5; s++)
      for (int k = 0; k < 5; k++) begin
        len = $urandom_range(1, 200); m = rnd_msg();
        do_run(3'(s), len, m, 1'b0, 1'b0, rc, rz, lat, p);
        ex = ref_rem(3'(s), len, m);
        chk(rc == ex, "R2 R5 random remainder", rc, ex);
        chk(rz == (ex == 0), "R6 zero flag tracks remainder", rz, ex == 0);
        chk(lat == ref_deg(3'(s)) && p, "R4 latency and pulse", lat, ref_deg(3'(s)));
      end
  endtask

  task automatic t_gaps();
    logic [39:0] rc, ex; logic rz; int lat; bit p; int len; logic [0:299] m;
    for (int s = 0; s < 5; s++) begin
      len = $urandom_range(2, 60); m = rnd_msg();
      do_run(3'(s), len, m, 1'b1, 1'b0, rc, rz, lat, p);
      ex = ref_rem(3'(s), len, m);
      chk(rc == ex, "R3 gaps between bits", rc, ex);
    end
  endtask

  task automatic t_alias();
    logic [39:0] rc, ex; logic rz; int lat; bit p; int len; logic [0:299] m;
    for (int s = 5; s < 8; s++) begin
      len = $urandom_range(1, 100); m = rnd_msg();
      do_run(3'(s), len, m, 1'b0, 1'b0, rc, rz, lat, p);
      ex = ref_rem(3'd0, len, m);
      chk(rc == ex && lat == 16, "R2 alias codes act as code 0", rc, ex);
    end
  endtask

  task automatic t_sel_ignored();
    logic [39:0] rc, ex; logic rz; int lat; bit p; int len; logic [0:299] m;
    for (int s = 0; s < 5; s++) begin
      len = $urandom_range(4, 80); m = rnd_msg();
      do_run(3'(s), len, m, 1'b0, 1'b1, rc, rz, lat, p);
      ex = ref_rem(3'(s), len, m);
      chk(rc == ex && lat == ref_deg(3'(s)), "R7 select and start ignored while busy", rc, ex);
    end
  endtask

  task automatic t_codeword();
    logic [39:0] rc, r; logic rz; int lat; bit p; int len, d, pos; logic [0:299] m;
    for (int s = 0; s < 5; s++) begin
      d = ref_deg(3'(s));
      len = $urandom_range(1, 150); m = rnd_msg();
      r = ref_rem(3'(s), len, m);
      for (int k = 0; k < d; k++) m[len+k] = r[d-1-k];
      do_run(3'(s), len + d, m, 1'b0, 1'b0, rc, rz, lat, p);
      chk(rz == 1'b1 && rc == 0, "R6 codeword gives zero remainder", rc, 0);
      pos = $urandom_range(0, len + d - 1);
      m[pos] = ~m[pos];
      do_run(3'(s), len + d, m, 1'b0, 1'b0, rc, rz, lat, p);
      chk(rz == 1'b0, "R6 corrupted codeword flagged", rz, 0);
    end
  endtask

  task automatic t_hold();
    logic [39:0] rc, ex; logic rz; int lat; bit p; logic [0:299] m; bit seen;
    m = rnd_msg();
    do_run(3'd1, 40, m, 1'b0, 1'b0, rc, rz, lat, p);
    ex = ref_rem(3'd1, 40, m);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      bit_valid_i = 1'b1; bit_i = 1'($urandom_range(0, 1)); last_i = 1'b1; sel_i = 3'(k);
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    bit_valid_i = 1'b0; last_i = 1'b0;
    chk(crc_o == ex, "R8 R9 result held while idle", crc_o, ex);
    chk(zero_o == (ex == 0), "R8 zero flag held", zero_o, ex == 0);
    chk(!seen, "R9 no done from idle bits", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_one();
    t_random_all();
    t_gaps();
    t_alias();
    t_sel_ignored();
    t_codeword();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule